// File: doc/BRIEF.md
# Network Controller Configuration Register Slice

This block holds a few dwords of a network controller's PCI configuration space behind a plain dword-wide register port with four byte write enables. It answers reads combinationally from the selected dword index and applies writes on the clock edge. It holds four things: the device revision, the class identification, the cache line size setting, and the upper half of the status register.

The revision is a fixed value. Its low bits can be replaced by a value loaded from the EEPROM. The class identification says that the device is an Ethernet network controller. The cache line size register takes only the two line sizes the device can use for memory write and invalidate bursts. Any other written value clears it, and the burst enable goes with it.

The status half reports three things. It shows the fixed fast back-to-back capability. It shows whether a capability list is present, which follows the EEPROM power-management bit. It also holds a sticky flag for parity errors seen during this agent's own master transfers, which software clears by writing one.

Top module: `nic_cfg_slice`

## Requirements
- R1: With no override (`rev_ovr_valid`=0), bits 7:0 of dword index 2 read 08h.
- R2: With `rev_ovr_valid`=1, bits 2:0 of dword index 2 read `rev_ovr_val` and bits 7:3 read 00001b.
- R3: Bits 31:8 of dword index 2 always read 020000h (base class 02h in 31:24, subclass 00h, interface 00h), and writes to that dword change nothing.
- R4: A write to dword index 3 with byte enable 0 set and a bits 7:0 value of 8 or 16 stores that value. From the next cycle `cls_eff`, read bits 7:0 of index 3 and `mwi_en`=1 reflect it.
- R5: A write to dword index 3 with byte enable 0 set and any other value makes `cls_eff`, read bits 7:0 of index 3 and `mwi_en` all 0 from the next cycle. `cls_eff` only ever holds 0, 8 or 16.
- R6: A write to dword index 3 with byte enable 0 clear leaves the cache line size and `mwi_en` unchanged.
- R7: The parity-error flag (bit 24 of dword index 1) becomes 1 in the cycle after `perr_seen`, `master_xfer` and `perr_resp_en` are all 1 together, and it is not set by any weaker combination.
- R8: A write to dword index 1 with byte enable 3 set and bit 24 of the write data equal to 1 clears the flag. A 0 in that bit, or byte enable 3 clear, leaves it unchanged.
- R9: When a set condition and a clear write fall in the same cycle, the flag ends up 1.
- R10: In dword index 1, bit 23 always reads 1, bit 20 reads `pm_cap_en`, bits 19:16 read 0, and writes do not change these bits.
- R11: While `rst_n` is low at a clock edge, the cache line size, `mwi_en` and the parity-error flag return to 0.
- R12: Dword indices other than 1, 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_addr | input | ADDR_W | Dword index of the access |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| rev_ovr_valid | input | 1 | EEPROM revision override present |
| rev_ovr_val | input | 3 | EEPROM revision low bits |
| pm_cap_en | input | 1 | EEPROM power-management bit |
| perr_seen | input | 1 | Parity error signalled or observed on the bus |
| master_xfer | input | 1 | This agent mastered the failing transfer |
| perr_resp_en | input | 1 | Parity error response enable from the command register |
| cls_eff | output | 8 | Effective cache line size in dwords |
| mwi_en | output | 1 | Memory write and invalidate allowed |

## Verification
Read data is combinational, so the revision, class, capability and constant status bits are due in the same cycle as the address or EEPROM input. The bench samples them 1 ns after it changes them. The cache line size, `mwi_en` and the parity-error flag are registered, so they are due one clock edge after the write or event strobe. The bench drives these on a falling edge and samples on the next falling edge, after exactly one rising edge. The sweeps cover every 8-bit cache line size value, every override value, and every combination of the three parity-error inputs with the previous flag state and the clear write.

// File: rtl/nic_cfg_pkg.sv
package nic_cfg_pkg;
    localparam int CFG_DW       = 32;
    localparam int CFG_BE_W     = CFG_DW / 8;
    // dword indices; positions fixed by the configuration space layout
    localparam int IDX_STATUS   = 1;
    localparam int IDX_REVCLASS = 2;
    localparam int IDX_LINESZ   = 3;
    // status bit positions decoded by software
    localparam int BIT_PERR     = 24;
    localparam int BIT_FASTB2B  = 23;
    localparam int BIT_CAPLIST  = 20;

    typedef struct packed {
        logic [7:0] line_sz;
        logic       burst_ok;
    } line_state_t;

    typedef struct packed {
        logic perr_flag;
    } perr_state_t;
endpackage

// File: rtl/cfg_line_size.sv
module cfg_line_size
    import nic_cfg_pkg::*;
#(
    parameter int SIZE_A = 8,
    parameter int SIZE_B = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wr_val,
    output logic [7:0] line_sz,
    output logic       burst_ok
);
    line_state_t st_d, st_q;
    logic        legal;

    always_comb begin
        legal = (wr_val == 8'(SIZE_A)) || (wr_val == 8'(SIZE_B));
        st_d  = st_q;
        if (wr_hit) begin
            if (legal) begin
                st_d.line_sz  = wr_val;
                st_d.burst_ok = 1'b1;
            end else begin
                st_d.line_sz  = '0;
                st_d.burst_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_sz  = st_q.line_sz;
    assign burst_ok = st_q.burst_ok;
endmodule

// File: rtl/cfg_perr_flag.sv
module cfg_perr_flag
    import nic_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic perr_seen,
    input  logic master_xfer,
    input  logic perr_resp_en,
    input  logic clr_hit,
    output logic perr_flag
);
    perr_state_t st_d, st_q;
    logic        set_cond;

    always_comb begin
        set_cond = perr_seen && master_xfer && perr_resp_en;
        st_d     = st_q;
        if (clr_hit)  st_d.perr_flag = 1'b0;
        if (set_cond) st_d.perr_flag = 1'b1;   // set has priority
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign perr_flag = st_q.perr_flag;
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import nic_cfg_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter logic [7:0] REV_BASE = 8'h08,
    parameter int         OVR_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rev_ovr_valid,
    input  logic [OVR_W-1:0]  rev_ovr_val,
    input  logic              pm_cap_en,
    input  logic              perr_flag,
    input  logic [7:0]        line_sz,
    output logic [CFG_DW-1:0] rdata
);
    localparam logic [23:0] CLASS_ID = 24'h020000;

    logic [7:0]        rev_eff;
    logic [CFG_DW-1:0] status_w;

    always_comb begin
        rev_eff = REV_BASE;
        if (rev_ovr_valid) rev_eff[OVR_W-1:0] = rev_ovr_val;

        status_w              = '0;
        status_w[BIT_PERR]    = perr_flag;
        status_w[BIT_FASTB2B] = 1'b1;
        status_w[BIT_CAPLIST] = pm_cap_en;

        unique case (addr)
            ADDR_W'(IDX_STATUS):   rdata = status_w;
            ADDR_W'(IDX_REVCLASS): rdata = {CLASS_ID, rev_eff};
            ADDR_W'(IDX_LINESZ):   rdata = {24'h0, line_sz};
            default:               rdata = '0;
        endcase
    end
endmodule

// File: rtl/nic_cfg_slice.sv
module nic_cfg_slice
    import nic_cfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              rev_ovr_valid,
    input  logic [2:0]        rev_ovr_val,
    input  logic              pm_cap_en,
    input  logic              perr_seen,
    input  logic              master_xfer,
    input  logic              perr_resp_en,
    output logic [7:0]        cls_eff,
    output logic              mwi_en
);
    logic line_wr_hit;
    logic perr_clr_hit;
    logic perr_q;
    logic unused_bits;

    assign line_wr_hit  = cfg_wr && (cfg_addr == ADDR_W'(IDX_LINESZ)) && cfg_be[0];
    assign perr_clr_hit = cfg_wr && (cfg_addr == ADDR_W'(IDX_STATUS)) && cfg_be[3]
                          && cfg_wdata[BIT_PERR];
    assign unused_bits  = ^{cfg_wdata[31:25], cfg_wdata[23:8], cfg_be[2:1]};

    cfg_line_size #(.SIZE_A(8), .SIZE_B(16)) i_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (line_wr_hit),
        .wr_val   (cfg_wdata[7:0]),
        .line_sz  (cls_eff),
        .burst_ok (mwi_en)
    );

    cfg_perr_flag i_perr (
        .clk          (clk),
        .rst_n        (rst_n),
        .perr_seen    (perr_seen),
        .master_xfer  (master_xfer),
        .perr_resp_en (perr_resp_en),
        .clr_hit      (perr_clr_hit),
        .perr_flag    (perr_q)
    );

    cfg_read_mux #(.ADDR_W(ADDR_W), .REV_BASE(8'h08), .OVR_W(3)) i_rmux (
        .addr          (cfg_addr),
        .rev_ovr_valid (rev_ovr_valid),
        .rev_ovr_val   (rev_ovr_val),
        .pm_cap_en     (pm_cap_en),
        .perr_flag     (perr_q),
        .line_sz       (cls_eff),
        .rdata         (cfg_rdata)
    );
endmodule

// File: rtl/nic_cfg_slice_chk.sv
module nic_cfg_slice_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr,
    input logic              be0,
    input logic              be3,
    input logic [7:0]        wdata_lo,
    input logic              wdata_perr,
    input logic [7:0]        rdata_st,
    input logic              pm_cap_en,
    input logic              perr_seen,
    input logic              master_xfer,
    input logic              perr_resp_en,
    input logic [7:0]        cls_eff,
    input logic              mwi_en,
    input logic              perr_q
);
    logic line_wr, set_c, clr_c;
    assign line_wr = cfg_wr && (cfg_addr == ADDR_W'(3)) && be0;
    assign set_c   = perr_seen && master_xfer && perr_resp_en;
    assign clr_c   = cfg_wr && (cfg_addr == ADDR_W'(1)) && be3 && wdata_perr;

    assert_cls_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_wr && (wdata_lo == 8'd8 || wdata_lo == 8'd16))
        |=> (cls_eff == $past(wdata_lo) && mwi_en));

    assert_cls_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_eff == 8'd0 || cls_eff == 8'd8 || cls_eff == 8'd16)
        && (mwi_en == (cls_eff != 8'd0)));

    assert_cls_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wr |=> ($stable(cls_eff) && $stable(mwi_en)));

    assert_perr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_c |=> perr_q);

    assert_perr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_c && !clr_c) |=> $stable(perr_q));

    assert_perr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_c && !set_c) |=> !perr_q);

    assert_status_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == ADDR_W'(1)) |-> (rdata_st[7] && rdata_st[3:0] == 4'h0
                                       && rdata_st[4] == pm_cap_en));

    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (cls_eff == 8'd0 && !mwi_en && !perr_q));
endmodule

bind nic_cfg_slice nic_cfg_slice_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_addr     (cfg_addr),
    .cfg_wr       (cfg_wr),
    .be0          (cfg_be[0]),
    .be3          (cfg_be[3]),
    .wdata_lo     (cfg_wdata[7:0]),
    .wdata_perr   (cfg_wdata[24]),
    .rdata_st     (cfg_rdata[23:16]),
    .pm_cap_en    (pm_cap_en),
    .perr_seen    (perr_seen),
    .master_xfer  (master_xfer),
    .perr_resp_en (perr_resp_en),
    .cls_eff      (cls_eff),
    .mwi_en       (mwi_en),
    .perr_q       (perr_q)
);

// File: tb/test_nic_cfg_slice.sv
`timescale 1ns/1ps
module test_nic_cfg_slice;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic              cfg_wr = 1'b0;
    logic [3:0]        cfg_be = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              rev_ovr_valid = 1'b0;
    logic [2:0]        rev_ovr_val = '0;
    logic              pm_cap_en = 1'b0;
    logic              perr_seen = 1'b0;
    logic              master_xfer = 1'b0;
    logic              perr_resp_en = 1'b0;
    logic [7:0]        cls_eff;
    logic              mwi_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    nic_cfg_slice #(.ADDR_W(ADDR_W)) i_nic_cfg_slice (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one write cycle: drive at falling edge, one rising edge, back to falling edge
    task automatic wr(input int idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = ADDR_W'(idx); cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        cfg_addr = ADDR_W'(idx);
        #1;
        d = cfg_rdata;
    endtask

    task automatic perr_cycle(input logic s, input logic m, input logic r,
                              input logic clr_en, input logic clr_bit);
        @(negedge clk);
        perr_seen = s; master_xfer = m; perr_resp_en = r;
        cfg_addr = ADDR_W'(1); cfg_be = {clr_en, 3'b000};
        cfg_wdata = {7'h0, clr_bit, 24'h0}; cfg_wr = clr_en | clr_bit;
        @(negedge clk);
        perr_seen = 0; master_xfer = 0; perr_resp_en = 0; cfg_wr = 0; cfg_be = '0;
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic        model;
        logic [7:0]  exp_cls;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        check("R11 cls", {24'h0, cls_eff}, 32'h0);
        check("R11 mwi", {31'h0, mwi_en}, 32'h0);
        rd(1, d); check("R11 perr flag", {31'h0, d[24]}, 32'h0);

        // R1 / R3: identification
        rd(2, d); check("R1 rev default", {24'h0, d[7:0]}, 32'h08);
        check("R3 class", {8'h0, d[31:8]}, 32'h020000);
        wr(2, 4'hF, 32'hFFFF_FFFF);
        rd(2, d); check("R3 write ignored", d, 32'h0200_0008);

        // R2: override sweep
        rev_ovr_valid = 1'b1;
        for (int v = 0; v < 8; v++) begin
            rev_ovr_val = 3'(v);
            rd(2, d);
            check("R2 rev override", {24'h0, d[7:0]}, 32'(8 + v));
        end
        rev_ovr_valid = 1'b0;

        // R4 / R5: every line size value
        for (int v = 0; v < 256; v++) begin
            wr(3, 4'h1, {24'hABCDEF, 8'(v)});
            exp_cls = (v == 8 || v == 16) ? 8'(v) : 8'h0;
            check((v == 8 || v == 16) ? "R4 cls accept" : "R5 cls reject",
                  {24'h0, cls_eff}, {24'h0, exp_cls});
            check("R5 mwi", {31'h0, mwi_en}, {31'h0, exp_cls != 0});
            rd(3, d); check("R4 cls read", d, {24'h0, exp_cls});
        end

        // R6: byte enable 0 clear leaves the value
        wr(3, 4'h1, 32'd16);
        wr(3, 4'hE, 32'd8);
        check("R6 be0 off cls", {24'h0, cls_eff}, 32'd16);
        wr(3, 4'hE, 32'd3);
        check("R6 be0 off mwi", {31'h0, mwi_en}, 32'h1);

        // R7 / R8 / R9: prior state x event combinations x clear write
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 8; s++)
                for (int c = 0; c < 4; c++) begin
                    if (p == 1) perr_cycle(1, 1, 1, 0, 0);
                    else        perr_cycle(0, 0, 0, 1, 1);
                    rd(1, d);
                    check("R7 prep", {31'h0, d[24]}, 32'(p));
                    perr_cycle(s[2], s[1], s[0], c[1], c[0]);
                    model = (s == 7) || ((p == 1) && !(c == 3));
                    rd(1, d);
                    check((s == 7 && c == 3) ? "R9 set wins" :
                          (c == 3) ? "R8 clear" : "R7 set/hold",
                          {31'h0, d[24]}, {31'h0, model});
                end

        // R10: constant status bits, capability follows pm bit
        for (int pm = 0; pm < 2; pm++) begin
            pm_cap_en = pm[0];
            wr(1, 4'hF, 32'h00EF_0000 ^ {11'h0, pm[0], 20'h0});
            rd(1, d);
            check("R10 status hi", {8'h0, d[23:16]}, {24'h0, 3'b100, pm[0], 4'h0});
        end
        pm_cap_en = 0;

        // R12: unmapped dwords
        foreach (d[i]) if (i < 4 && i != 1 && i != 2 && i != 3) begin
            rd(i, d); check("R12 unmapped", d, 32'h0);
        end
        for (int i = 4; i < 64; i += 9) begin
            rd(i, d); check("R12 unmapped", d, 32'h0);
        end

        // R11: reset mid-run
        wr(3, 4'h1, 32'd8);
        perr_cycle(1, 1, 1, 0, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R11 cls after reset", {24'h0, cls_eff}, 32'h0);
        check("R11 mwi after reset", {31'h0, mwi_en}, 32'h0);
        rd(1, d); check("R11 flag after reset", {31'h0, d[24]}, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule